// File: doc/BRIEF.md
# Active Miller Clamp Output-Stage Sequencer

This block sequences the three switches of one gate-driver output stage: a pull-up device that charges the power switch gate, a main pull-down device that discharges it, and an auxiliary clamp pull-down. The clamp ties the discharged gate to the emitter rail through a low-impedance path. Its purpose is to stop fast collector or drain voltage swings from coupling charge through the Miller capacitance and turning the switch back on.

The block has two inputs. The first is an already-filtered command level. The second is a digital flag from an external comparator that is high while the sensed gate voltage is below the clamp threshold. The pull-up and the main pull-down are never on in the same cycle. A one-cycle dead gap with every switch off separates the two in either direction.

Once the clamp is engaged, it ignores above-threshold bumps shorter than a programmable filter window, so dv/dt spikes do not release it. A sustained rise releases it. All pins are plain control levels; there is no streaming interface and no back-pressure.

Top module: `miller_clamp_seq`

## Requirements
- R1: While reset is asserted, and after it is released with the command low, the pull-up is off, the main pull-down is on and the clamp is off.
- R2: The pull-up is never on in the same cycle as the main pull-down or the clamp.
- R3: A high command sampled while the main pull-down is on turns every switch off at the next edge. If the command is still high at the following edge, the pull-up turns on there.
- R4: A low command sampled while the pull-up is on turns every switch off at the next edge. If the command is still low at the following edge, the main pull-down turns on there.
- R5: With the main pull-down on and the command low, a sampled below-threshold flag of 1 turns the clamp on at the next edge.
- R6: While the clamp is on, a run of fewer than FILT_CYC consecutive sampled flag values of 0 leaves the clamp on. A sampled 1 restarts the count.
- R7: The FILT_CYC-th consecutive sampled 0 turns the clamp off at that edge. The clamp stays off until a 1 is sampled again.
- R8: A high command sampled while the clamp is on turns the clamp off at the next edge and clears the excursion count.
- R9: The clamp is only ever on while the main pull-down is on.
- R10: A command pulse that reverses during the dead gap cycle returns to the previous drive side after that single gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 1 | Filtered drive command, 1 = gate on |
| gate_below_i | input | 1 | Comparator flag, 1 = gate below clamp threshold |
| pu_en_o | output | 1 | Pull-up switch enable |
| pd_en_o | output | 1 | Main pull-down switch enable |
| clamp_en_o | output | 1 | Clamp pull-down switch enable |

## Verification
The hardest situation to reach from the ports is the exact boundary of the filter window. One run of zeros must stop one cycle short of FILT_CYC and keep the clamp. The next run must reach FILT_CYC exactly and release it. The bench builds both runs with the default filter shortened, and re-arms the count with a single 1 between them.

A second hard case is a command that reverses during the dead gap. The bench issues one-cycle pulses in both directions and checks that each gap lasts exactly one cycle and that the clamp does not re-engage during the gap.

// File: rtl/miller_pkg.sv
package miller_pkg;
  typedef enum logic [1:0] {
    DRV_LOW  = 2'd0,
    GAP_RISE = 2'd1,
    DRV_HIGH = 2'd2,
    GAP_FALL = 2'd3
  } drv_state_e;
endpackage

// File: rtl/drive_bbm_fsm.sv
module drive_bbm_fsm
  import miller_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  output logic pu_o,
  output logic pd_o
);
  drv_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      DRV_LOW:  if (cmd_i)  st_d = GAP_RISE;
      GAP_RISE: st_d = cmd_i ? DRV_HIGH : DRV_LOW;
      DRV_HIGH: if (!cmd_i) st_d = GAP_FALL;
      GAP_FALL: st_d = cmd_i ? DRV_HIGH : DRV_LOW;
      default:  st_d = DRV_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DRV_LOW;
    else        st_q <= st_d;
  end

  assign pu_o = (st_q == DRV_HIGH);
  assign pd_o = (st_q == DRV_LOW);

  // R2: pull-up and pull-down never overlap
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_o && pd_o));
  // R3: pull-down on in one cycle means pull-up off in the next
  a_r3_gap_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |=> !pu_o);
  // R4: pull-up on in one cycle means pull-down off in the next
  a_r4_gap_fall: assert property (@(posedge clk) disable iff (!rst_n)
    pu_o |=> !pd_o);
endmodule

// File: rtl/clamp_filter.sv
module clamp_filter #(
  parameter int FILT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_active_i,
  input  logic cmd_i,
  input  logic below_i,
  output logic clamp_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [CW-1:0] run_q;
  logic          clamp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clamp_q <= 1'b0;
      run_q   <= '0;
    end else if (cmd_i || !low_active_i) begin
      clamp_q <= 1'b0;
      run_q   <= '0;
    end else if (!clamp_q) begin
      clamp_q <= below_i;
      run_q   <= '0;
    end else if (below_i) begin
      run_q   <= '0;
    end else if (run_q == LAST) begin
      clamp_q <= 1'b0;
      run_q   <= '0;
    end else begin
      run_q   <= run_q + 1'b1;
    end
  end

  assign clamp_o = clamp_q;

  // R5: engage after a below-threshold sample in the low drive state
  a_r5_engage: assert property (@(posedge clk) disable iff (!rst_n)
    (low_active_i && !cmd_i && below_i) |=> clamp_o);
  // R8: a high command releases the clamp at the next edge
  a_r8_cmd_release: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_i |=> !clamp_o);
  // R6: a below-threshold sample with the clamp on keeps it on
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (clamp_o && below_i && !cmd_i && low_active_i) |=> clamp_o);
endmodule

// File: rtl/miller_clamp_seq.sv
module miller_clamp_seq #(
  parameter int FILT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_i,
  input  logic gate_below_i,
  output logic pu_en_o,
  output logic pd_en_o,
  output logic clamp_en_o
);
  logic pu_w, pd_w, clamp_w;

  drive_bbm_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .cmd_i (cmd_i),
    .pu_o  (pu_w),
    .pd_o  (pd_w)
  );

  clamp_filter #(.FILT_CYC(FILT_CYC)) u_clamp (
    .clk          (clk),
    .rst_n        (rst_n),
    .low_active_i (pd_w),
    .cmd_i        (cmd_i),
    .below_i      (gate_below_i),
    .clamp_o      (clamp_w)
  );

  assign pu_en_o    = pu_w;
  assign pd_en_o    = pd_w;
  assign clamp_en_o = clamp_w;

  // R9: clamp only while the main pull-down conducts
  a_r9_clamp_needs_pd: assert property (@(posedge clk) disable iff (!rst_n)
    clamp_en_o |-> pd_en_o);
  // R2: pull-up never with clamp
  a_r2_no_pu_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    !(pu_en_o && clamp_en_o));
endmodule

// File: tb/miller_clamp_seq_test.sv
module miller_clamp_seq_test;
  localparam int F = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd = 1'b0;
  logic below = 1'b0;
  logic pu, pd, cl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic  pu;
    logic  pd;
    logic  cl;
    string tag;
  } exp_t;

  exp_t q[$];

  miller_clamp_seq #(.FILT_CYC(F)) uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_i        (cmd),
    .gate_below_i (below),
    .pu_en_o      (pu),
    .pd_en_o      (pd),
    .clamp_en_o   (cl)
  );

  always #10 clk = ~clk;

  task automatic compare(input logic e_pu, input logic e_pd, input logic e_cl, input string tag);
    checks++;
    if (pu !== e_pu || pd !== e_pd || cl !== e_cl) begin
      errors++;
      $display("FAIL %s: got pu=%b pd=%b cl=%b expected pu=%b pd=%b cl=%b",
               tag, pu, pd, cl, e_pu, e_pd, e_cl);
    end
  endtask

  task automatic step(input logic c, input logic b, input logic e_pu,
                      input logic e_pd, input logic e_cl, input string tag);
    exp_t it;
    @(negedge clk);
    cmd = c;
    below = b;
    it.pu = e_pu; it.pd = e_pd; it.cl = e_cl; it.tag = tag;
    q.push_back(it);
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      compare(it.pu, it.pd, it.cl, it.tag);
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    compare(1'b0, 1'b1, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    step(0, 0, 0, 1, 0, "R1 after reset");
    step(0, 1, 0, 1, 1, "R5 engage");
    for (int i = 0; i < F - 1; i++) step(0, 0, 0, 1, 1, "R6 short bump");
    step(0, 1, 0, 1, 1, "R6 rearm");
    for (int i = 0; i < F - 1; i++) step(0, 0, 0, 1, 1, "R6 before limit");
    step(0, 0, 0, 1, 0, "R7 release");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0, "R7 stays off");
    step(0, 1, 0, 1, 1, "R5 reengage");
    step(1, 1, 0, 0, 0, "R8 cmd release");
    step(1, 1, 1, 0, 0, "R3 pull-up on");
    step(1, 0, 1, 0, 0, "R3 hold high");
    step(0, 1, 0, 0, 0, "R4 gap");
    step(0, 1, 0, 1, 0, "R9 no clamp in gap");
    step(0, 1, 0, 1, 1, "R5 after fall");
    step(1, 1, 0, 0, 0, "R10 rise gap");
    step(0, 1, 0, 1, 0, "R10 back low");
    step(0, 1, 0, 1, 1, "R5 after pulse");
    step(1, 0, 0, 0, 0, "R3 gap");
    step(1, 0, 1, 0, 0, "R3 high");
    step(0, 0, 0, 0, 0, "R4 gap");
    step(1, 0, 1, 0, 0, "R10 back high");
    step(0, 0, 0, 0, 0, "R4 gap2");
    step(0, 1, 0, 1, 0, "R4 pull-down on");
    step(0, 1, 0, 1, 1, "R5 engage again");
    step(0, 0, 0, 1, 1, "R6 one zero");
    step(1, 0, 0, 0, 0, "R8 mid excursion");
    step(0, 1, 0, 1, 0, "R4 low after pulse");
    step(0, 1, 0, 1, 1, "R5 engage third");
    for (int i = 0; i < F - 1; i++) step(0, 0, 0, 1, 1, "R8 count cleared");
    step(0, 0, 0, 1, 0, "R7 release again");
    step(1, 0, 0, 0, 0, "R2 gap");
    step(1, 0, 1, 0, 0, "R2 high only");
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    compare(1'b0, 1'b1, 1'b0, "R1 reset from high");
    @(negedge clk);
    compare(1'b0, 1'b1, 1'b0, "R1 held in reset");
    finish_run();
  end
endmodule